// File: doc/BRIEF.md
# Eight-Channel DMA Transfer Engine

This block is a direct-memory-access engine with eight channels and one bus master port. The port is its own, so the engine copies data from one address to another while the processor keeps working on its own path. Each channel holds a 32-bit source address and a 32-bit destination address. It also holds an element width (byte, half-word or word), a block size of 1 to 16 elements and a transfer count of 1 to 65536 blocks. Software programs a channel through a small write-only configuration port. A channel is started by a software trigger or by an on-chip peripheral request line.

A channel runs in one of three modes. Block mode moves one block for each trigger. Burst mode moves all of its blocks after a single trigger. Demand mode keeps moving blocks for as long as the peripheral holds its request line high. When several channels are ready, the engine serves the lowest-numbered one, and it chooses a channel only between blocks. When a channel's last block is finished, the channel disables itself, sets a done flag and, if its interrupt is enabled, raises an interrupt line.

Each element moves as one read beat followed by one write beat on a single-beat request/acknowledge bus. Data on the bus is right-justified, meaning the element sits in the low-order bits.

Top module: `dma8_engine`

## Requirements
- R1: After reset the bus request, every done flag and every interrupt line are low.
- R2: In block mode (mode code 0), each trigger moves exactly one block of (block field + 1) elements. The channel then stays idle until the next trigger. A software trigger is a write to register select 3 with bit n set for channel n.
- R3: Both counts are stored minus one: block field in control bits [15:12], transfer field in bits [31:16]. A channel moves (block+1)×(transfer+1) elements in total, and the addresses carry on from one block to the next.
- R4: The width code in control bits [2:1] selects the element width: 0 is a byte, 1 is a half-word, 2 is a word, and 3 is stored as 2. The bus size output carries the same code. Each element is written with only its low 1, 2 or 4 bytes taken from the read data; all higher bits are zero.
- R5: After each element, an address steps by the element size in bytes unless its fixed bit is set. Control bit 5 fixes the source address and bit 6 fixes the destination address.
- R6: In burst mode (mode code 1, control bits [4:3]), one trigger moves every block of the channel.
- R7: In demand mode (mode code 2), blocks keep moving while the channel's request input is high. The channel stops after the block during which the request falls, and it does not set its done flag while blocks remain.
- R8: In block and burst modes, a rising edge on a channel's request input acts as one trigger. A request held high causes no further transfers.
- R9: When several channels are ready, the lowest-numbered channel is served first. A channel that becomes ready in the middle of another channel's block waits until that block has finished.
- R10: At the end of the last block, the channel clears its enable and sets its done flag. Its interrupt line rises only if control bit 7 is set. Writing the control register (select 2) with bit 0 set clears the done flag and reloads the counts.
- R11: Each element is one read beat and then one write beat. The request, address and direction outputs stay stable until acknowledge is seen, and the request is low when no channel is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 3 | Channel addressed by the write |
| cfg_sel | input | 2 | 0 source, 1 destination, 2 control, 3 trigger mask |
| cfg_wdata | input | 32 | Configuration write data |
| dreq_i | input | 8 | Peripheral request lines, one per channel |
| m_req | output | 1 | Bus beat request |
| m_we | output | 1 | Beat is a write |
| m_addr | output | 32 | Beat address |
| m_size | output | 2 | Element width code |
| m_wdata | output | 32 | Right-justified write data |
| m_rdata | input | 32 | Right-justified read data |
| m_ack | input | 1 | Beat acknowledge |
| done_o | output | 8 | Per-channel done flags |
| irq_o | output | 8 | Per-channel interrupt lines |

## Verification
The write beats reveal almost every internal fault within one beat. The bench predicts each beat's address, width and data, so a wrong address step, a wrong width mask or a fixed bit that is ignored shows up as a mismatch. A wrong grant or a block that is interrupted by another channel shows up as beats arriving out of order. A count that is off by one appears later, at the end of the channel's final block: the bench sees either an extra write beat it did not expect, or a done flag that does not match after the bus falls quiet. Demand and edge-triggered starts are checked by holding or dropping the request lines and confirming that no further beats appear.

// File: rtl/dma8_engine.sv
module dma8_engine #(
  parameter int NCH  = 8,
  parameter int AW   = 32,
  parameter int BLKW = 4,
  parameter int TRW  = 16,
  localparam int CW  = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [CW-1:0] cfg_ch,
  input  logic [1:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  input  logic [NCH-1:0] dreq_i,
  output logic          m_req,
  output logic          m_we,
  output logic [AW-1:0] m_addr,
  output logic [1:0]    m_size,
  output logic [31:0]   m_wdata,
  input  logic [31:0]   m_rdata,
  input  logic          m_ack,
  output logic [NCH-1:0] done_o,
  output logic [NCH-1:0] irq_o
);
  localparam logic [1:0] M_BURST  = 2'd1;
  localparam logic [1:0] M_DEMAND = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;

  logic [AW-1:0]   src_q [NCH];
  logic [AW-1:0]   dst_q [NCH];
  logic [1:0]      size_q [NCH];
  logic [1:0]      mode_q [NCH];
  logic [BLKW-1:0] blk_q [NCH];
  logic [TRW-1:0]  tleft_q [NCH];
  logic [NCH-1:0]  en_q, sfix_q, dfix_q, ie_q, pend_q, run_q, done_q, req_q;

  st_t             st;
  logic [CW-1:0]   cur, gnt;
  logic [BLKW-1:0] ecnt;
  logic [31:0]     dat_q;
  logic [NCH-1:0]  elig;
  logic [AW-1:0]   step;
  logic [31:0]     rmask;
  logic            unused_bits;

  assign unused_bits = ^cfg_wdata[11:8];

  always_comb begin
    for (int i = 0; i < NCH; i++)
      elig[i] = en_q[i] & (pend_q[i] | run_q[i] | (mode_q[i] == M_DEMAND && dreq_i[i]));
    gnt = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (elig[i]) gnt = CW'(i);
  end

  assign step    = AW'(1) << size_q[cur];
  assign rmask   = (size_q[cur] == 2'd0) ? 32'h0000_00FF :
                   (size_q[cur] == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  assign m_req   = (st != S_IDLE);
  assign m_we    = (st == S_WR);
  assign m_addr  = (st == S_WR) ? dst_q[cur] : src_q[cur];
  assign m_size  = size_q[cur];
  assign m_wdata = dat_q;
  assign done_o  = done_q;
  assign irq_o   = done_q & ie_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        src_q[i]   <= '0;
        dst_q[i]   <= '0;
        size_q[i]  <= '0;
        mode_q[i]  <= '0;
        blk_q[i]   <= '0;
        tleft_q[i] <= '0;
      end
      {en_q, sfix_q, dfix_q, ie_q} <= '0;
      {pend_q, run_q, done_q, req_q} <= '0;
      st    <= S_IDLE;
      cur   <= '0;
      ecnt  <= '0;
      dat_q <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (|elig) begin
          cur         <= gnt;
          ecnt        <= '0;
          pend_q[gnt] <= 1'b0;
          if (mode_q[gnt] == M_BURST) run_q[gnt] <= 1'b1;
          st          <= S_RD;
        end
        S_RD: if (m_ack) begin
          dat_q <= m_rdata & rmask;
          st    <= S_WR;
        end
        S_WR: if (m_ack) begin
          if (!sfix_q[cur]) src_q[cur] <= src_q[cur] + step;
          if (!dfix_q[cur]) dst_q[cur] <= dst_q[cur] + step;
          if (ecnt == blk_q[cur]) begin
            st <= S_IDLE;
            if (tleft_q[cur] == '0) begin
              en_q[cur]   <= 1'b0;
              run_q[cur]  <= 1'b0;
              done_q[cur] <= 1'b1;
            end else begin
              tleft_q[cur] <= tleft_q[cur] - 1'b1;
            end
          end else begin
            ecnt <= ecnt + 1'b1;
            st   <= S_RD;
          end
        end
        default: st <= S_IDLE;
      endcase

      for (int i = 0; i < NCH; i++) begin
        req_q[i] <= dreq_i[i];
        if (dreq_i[i] && !req_q[i] && en_q[i] && mode_q[i] != M_DEMAND)
          pend_q[i] <= 1'b1;
      end

      if (cfg_we) begin
        unique case (cfg_sel)
          2'd0: src_q[cfg_ch] <= AW'(cfg_wdata);
          2'd1: dst_q[cfg_ch] <= AW'(cfg_wdata);
          2'd2: begin
            en_q[cfg_ch]    <= cfg_wdata[0];
            size_q[cfg_ch]  <= (cfg_wdata[2:1] == 2'd3) ? 2'd2 : cfg_wdata[2:1];
            mode_q[cfg_ch]  <= cfg_wdata[4:3];
            sfix_q[cfg_ch]  <= cfg_wdata[5];
            dfix_q[cfg_ch]  <= cfg_wdata[6];
            ie_q[cfg_ch]    <= cfg_wdata[7];
            blk_q[cfg_ch]   <= cfg_wdata[12 +: BLKW];
            tleft_q[cfg_ch] <= cfg_wdata[16 +: TRW];
            run_q[cfg_ch]   <= 1'b0;
            pend_q[cfg_ch]  <= 1'b0;
            if (cfg_wdata[0]) done_q[cfg_ch] <= 1'b0;
          end
          default: for (int i = 0; i < NCH; i++)
            if (cfg_wdata[i]) pend_q[i] <= 1'b1;
        endcase
      end
    end
  end

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && !m_ack) |=> (m_req && $stable(m_addr) && $stable(m_we)));

  a_r11_rd_then_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && !m_we && m_ack) |=> (m_req && m_we));

  a_r4_size_code: assert property (@(posedge clk) disable iff (!rst_n)
    m_req |-> (m_size != 2'd3));

  a_r9_no_preempt: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && $past(st) != S_IDLE) |-> (cur == $past(cur)));

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    a_r10_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q[g]) |-> $past(st == S_WR && m_ack && cur == CW'(g)));
  end
endmodule

// File: tb/dma8_engine_tb_top.sv
module dma8_engine_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_ch = '0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [7:0]  dreq = '0;
  logic        m_req, m_we, m_ack;
  logic [31:0] m_addr, m_wdata, m_rdata;
  logic [1:0]  m_size;
  logic [7:0]  done_o, irq_o;

  dma8_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .dreq_i(dreq), .m_req(m_req), .m_we(m_we), .m_addr(m_addr),
    .m_size(m_size), .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ack(m_ack),
    .done_o(done_o), .irq_o(irq_o));

  typedef struct {
    logic [31:0] a;
    logic [1:0]  sz;
    logic [31:0] d;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0, nwr = 0, lat_sel = 0, wcnt = 0;
  logic [7:0]  mem [0:4095];
  logic [31:0] rd;

  function automatic logic [7:0] pat(input int unsigned a);
    return 8'((a * 7 + 3) ^ (a >> 5));
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bus slave: variable latency, junk above the element in read data
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ack <= 1'b0;
      m_rdata <= '0;
      wcnt <= 0;
    end else if (m_ack) begin
      if (m_we)
        for (int k = 0; k < (1 << m_size); k++) mem[12'(m_addr + k)] <= m_wdata[8*k +: 8];
      m_ack <= 1'b0;
      lat_sel <= lat_sel + 1;
      wcnt <= 0;
    end else if (m_req) begin
      if (wcnt >= lat_sel % 3) begin
        rd = 32'hA5A5_A5A5;
        for (int k = 0; k < (1 << m_size); k++) rd[8*k +: 8] = mem[12'(m_addr + k)];
        m_rdata <= rd;
        m_ack <= 1'b1;
      end else wcnt <= wcnt + 1;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && m_req && m_we && m_ack) begin
      nwr++;
      if (q.size() == 0) chk(1'b0, "R9 unexpected write beat", m_addr, 32'hFFFF_FFFF);
      else begin
        exp_t x;
        x = q.pop_front();
        chk(m_addr == x.a, {x.tag, " addr"}, m_addr, x.a);
        chk(m_wdata == x.d && m_size == x.sz, {x.tag, " data"}, m_wdata, x.d);
      end
    end
  end

  task automatic push(input logic [31:0] s, input logic [31:0] d, input int sz,
                      input bit sf, input bit df, input int n, input string tag);
    for (int e = 0; e < n; e++) begin
      exp_t x;
      logic [31:0] v;
      v = '0;
      for (int k = 0; k < (1 << sz); k++) v[8*k +: 8] = pat((s + k) & 32'hFFF);
      x.a = d; x.sz = 2'(sz); x.d = v; x.tag = tag;
      q.push_back(x);
      if (!sf) s += (1 << sz);
      if (!df) d += (1 << sz);
    end
  endtask

  task automatic cfgw(input int ch, input int sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 3'(ch); cfg_sel = 2'(sel); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [31:0] mkctl(input bit en, input int sz, input int mode, input bit sf,
                                        input bit df, input bit ie, input int blkm1, input int trnm1);
    return {16'(trnm1), 4'(blkm1), 4'b0, ie, df, sf, 2'(mode), 2'(sz), en};
  endfunction

  task automatic setup(input int ch, input logic [31:0] s, input logic [31:0] d, input logic [31:0] ctl);
    cfgw(ch, 0, s);
    cfgw(ch, 1, d);
    cfgw(ch, 2, ctl);
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (12) @(negedge clk);
    chk(m_req == 1'b0, "R11 request low when idle", 32'(m_req), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int base;
    for (int a = 0; a < 4096; a++) mem[a] = pat(a);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(m_req == 1'b0, "R1 reset request", 32'(m_req), 0);
    chk(done_o == 8'h00, "R1 reset done", 32'(done_o), 0);
    chk(irq_o == 8'h00, "R1 reset irq", 32'(irq_o), 0);

    // R2 R3: block mode, word, 4 elements x 2 transfers
    setup(1, 32'h100, 32'h800, mkctl(1, 2, 0, 0, 0, 1, 3, 1));
    push(32'h100, 32'h800, 2, 0, 0, 4, "R2 block one");
    cfgw(0, 3, 32'h02);
    drain();
    chk(done_o[1] == 1'b0, "R2 one block per trigger", 32'(done_o[1]), 0);
    push(32'h110, 32'h810, 2, 0, 0, 4, "R3 addresses continue");
    cfgw(0, 3, 32'h02);
    drain();
    chk(done_o[1] == 1'b1, "R10 done after last block", 32'(done_o[1]), 1);
    chk(irq_o[1] == 1'b1, "R10 irq enabled", 32'(irq_o[1]), 1);

    // R4 R6: burst bytes with junk upper read bits, no interrupt
    setup(2, 32'h203, 32'h900, mkctl(1, 0, 1, 0, 0, 0, 2, 1));
    push(32'h203, 32'h900, 0, 0, 0, 6, "R4 R6 burst bytes");
    cfgw(0, 3, 32'h04);
    drain();
    chk(done_o[2] == 1'b1, "R6 burst done", 32'(done_o[2]), 1);
    chk(irq_o[2] == 1'b0, "R10 irq disabled", 32'(irq_o[2]), 0);
    setup(2, 32'h300, 32'hA00, mkctl(1, 1, 1, 0, 0, 1, 0, 3));
    chk(done_o[2] == 1'b0, "R10 done cleared on enable", 32'(done_o[2]), 0);
    push(32'h300, 32'hA00, 1, 0, 0, 4, "R4 burst halfwords");
    cfgw(0, 3, 32'h04);
    drain();

    // R5 fixed addresses
    setup(4, 32'h400, 32'hB00, mkctl(1, 2, 1, 1, 0, 1, 1, 1));
    push(32'h400, 32'hB00, 2, 1, 0, 4, "R5 fixed source");
    cfgw(0, 3, 32'h10);
    drain();
    setup(5, 32'h480, 32'hC00, mkctl(1, 0, 1, 0, 1, 1, 3, 0));
    push(32'h480, 32'hC00, 0, 0, 1, 4, "R5 fixed destination");
    cfgw(0, 3, 32'h20);
    drain();
    chk(done_o[5:4] == 2'b11, "R5 both done", 32'(done_o[5:4]), 3);

    // R8 peripheral edge in block mode; held level gives nothing more
    setup(6, 32'h500, 32'hD00, mkctl(1, 2, 0, 0, 0, 1, 1, 2));
    push(32'h500, 32'hD00, 2, 0, 0, 2, "R8 edge start");
    @(negedge clk) dreq[6] = 1'b1;
    drain();
    repeat (30) @(negedge clk);
    chk(done_o[6] == 1'b0, "R8 held request no retrigger", 32'(done_o[6]), 0);
    dreq[6] = 1'b0;
    repeat (3) @(negedge clk);
    push(32'h508, 32'hD08, 2, 0, 0, 2, "R8 second edge");
    dreq[6] = 1'b1;
    drain();
    dreq[6] = 1'b0;

    // R7 demand mode: drop request in second block
    setup(7, 32'h600, 32'hE00, mkctl(1, 2, 2, 0, 0, 1, 3, 9));
    push(32'h600, 32'hE00, 2, 0, 0, 8, "R7 demand");
    base = nwr;
    @(negedge clk) dreq[7] = 1'b1;
    while (nwr < base + 5) @(negedge clk);
    dreq[7] = 1'b0;
    drain();
    repeat (20) @(negedge clk);
    chk(done_o[7] == 1'b0, "R7 demand stops without done", 32'(done_o[7]), 0);

    // R9 priority: simultaneous triggers
    setup(0, 32'hF000_0700, 32'hF00, mkctl(1, 2, 0, 0, 0, 1, 3, 0));
    setup(3, 32'h780, 32'hF80, mkctl(1, 2, 0, 0, 0, 1, 3, 0));
    push(32'hF000_0700, 32'hF00, 2, 0, 0, 4, "R9 lowest first ch0");
    push(32'h780, 32'hF80, 2, 0, 0, 4, "R9 then ch3");
    cfgw(0, 3, 32'h09);
    drain();
    chk(done_o[0] == 1'b1 && done_o[3] == 1'b1, "R9 both done", 32'(done_o), 32'h09);

    // R9 no preemption mid-block
    setup(0, 32'h040, 32'h840, mkctl(1, 2, 0, 0, 0, 1, 3, 0));
    setup(3, 32'h080, 32'h880, mkctl(1, 2, 0, 0, 0, 1, 3, 0));
    push(32'h080, 32'h880, 2, 0, 0, 4, "R9 ch3 block not preempted");
    push(32'h040, 32'h840, 2, 0, 0, 4, "R9 ch0 after boundary");
    base = nwr;
    cfgw(0, 3, 32'h08);
    while (nwr < base + 1) @(negedge clk);
    cfgw(0, 3, 32'h01);
    drain();
    chk(irq_o[0] == 1'b1 && irq_o[3] == 1'b1, "R10 irq both", 32'(irq_o), 32'h09);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule